// File: doc/BRIEF.md
# Idle Packet Integrity Checker

This block watches idle (time-fill) packets that arrive on four parallel byte lanes: one master lane and three slave lanes, one byte per lane per clock when the valid input is high. Every lane carries a 16-byte slot. The block keeps one 8-bit CRC register per lane. Bytes 0 to 14 of a slot are folded into that register. Byte 15 is compared against the register, and the register then takes the received byte. Lane CRC state therefore runs on from one idle packet to the next and is never re-seeded by packet boundaries.

The master lane also carries the header: the packet qualifier in byte 0, followed by the output-queue-grant bytes. The header must have even parity. It spans three bytes in 16-port mode and five bytes in 32-port mode. A qualifier of 8'h48 identifies a yellow packet. When yellow detection is enabled, such a packet raises a one-cycle interrupt. Otherwise it is treated like any other idle packet. All error and interrupt outputs are one-cycle pulses that appear in the cycle after the last byte of a slot.

Top module: `idle_pkt_checker`

## Requirements
- R1: After synchronous active-low reset, every lane CRC register holds `crc_seed`, the byte position is 0, and `crc_err`, `parity_err` and `yellow_irq` are 0.
- R2: The byte position advances by one, wrapping 15 to 0, only on cycles with `in_valid` high. Cycles with `in_valid` low neither advance it nor affect any register, whatever the lane data.
- R3: Lane l carries bits [8l+7:8l] of `lane_data`, and lane 0 is the master. For bytes 0..14 the lane CRC is advanced MSB-first with the polynomial x^8+x^4+x^3+x^2+1 (8'h1D). At byte 15, `crc_err[l]` is set in the next cycle exactly when the received byte differs from the lane register, independently for each lane.
- R4: After byte 15 the lane register holds the received byte 15, so the CRC accumulates across packets.
- R5: With `wide_mode`=0, `parity_err` pulses after byte 15 when the XOR of all bits of master-lane bytes 0..2 is 1. Master bytes 3 and 4 are then not part of the check.
- R6: With `wide_mode`=1, the parity covers master-lane bytes 0..4.
- R7: When master byte 0 equals 8'h48 and `yellow_en` is 1 at byte 15, `yellow_irq` pulses in the cycle after byte 15. With `yellow_en`=0 no pulse appears, and the packet is checked like any idle packet.
- R8: A cycle with `seed_load` high loads `crc_seed` into every lane register, taking priority over byte processing.
- R9: `crc_err`, `parity_err` and `yellow_irq` are high only in the single cycle following an accepted byte 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One byte per lane is present this cycle |
| lane_data | input | 32 | Four lane bytes, lane 0 (master) in bits 7:0 |
| wide_mode | input | 1 | 0: 3-byte header parity, 1: 5-byte header parity |
| yellow_en | input | 1 | Enables the yellow-packet interrupt |
| crc_seed | input | 8 | Initial CRC value for all lanes |
| seed_load | input | 1 | Reload all lane CRC registers from crc_seed |
| crc_err | output | 4 | Per-lane CRC mismatch pulse |
| parity_err | output | 1 | Header parity error pulse |
| yellow_irq | output | 1 | Yellow packet detected pulse |

## Verification
The properties assume that the first accepted byte after reset is byte 0 of a slot. They also assume that `seed_load` is only raised between slots, and that `wide_mode` and `yellow_en` do not change inside a slot. The stimulus holds these inputs steady while it sends a packet, pulses the seed load only while valid is low, and inserts idle cycles carrying random data between bytes. The reference model counts positions only on accepted bytes, so it stays aligned to the slot.

// File: rtl/idle_chk_pkg.sv
// Shared constants and the CRC step used by every lane of the idle packet checker.
// Assumes bytes are processed MSB first.
package idle_chk_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Advance an 8-bit CRC by one byte, shifting MSB first, Galois form.
    function automatic byte_t crc8_advance(input byte_t cur, input byte_t din, input byte_t poly);
        byte_t c;
        c = cur;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (c[BYTE_W-1] ^ din[i])
                c = (c << 1) ^ poly;
            else
                c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/slot_tracker.sv
// Tracks the byte position inside a lane slot.
// Assumes the first accepted byte after reset is byte 0. It advances only on valid cycles.
module slot_tracker #(
    parameter int SLOT_BYTES = 16,
    localparam int POS_W = $clog2(SLOT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic [POS_W-1:0] pos,
    output logic             last_beat
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BYTES - 1);

    assign last_beat = (pos == LAST_POS);

    // Step the position on each accepted byte and wrap after the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (in_valid)
            pos <= last_beat ? '0 : pos + 1'b1;
    end

endmodule

// File: rtl/lane_crc.sv
// One lane's running CRC. Payload bytes advance the register. The final slot byte is
// compared with it and then replaces it, so the state runs on across packets.
// Assumes seed_load is raised only between slots.
module lane_crc
    import idle_chk_pkg::*;
#(
    parameter byte_t POLY = 8'h1D
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  last_beat,
    input  logic  seed_load,
    input  byte_t seed,
    input  byte_t din,
    output byte_t crc_q,
    output logic  err_pulse
);

    // Hold the running CRC and raise a one-cycle mismatch flag at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= seed;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (in_valid && last_beat)
                err_pulse <= (din != crc_q);
            if (seed_load)
                crc_q <= seed;
            else if (in_valid)
                crc_q <= last_beat ? din : crc8_advance(crc_q, din, POLY);
        end
    end

endmodule

// File: rtl/header_check.sv
// Master-lane header checks. It accumulates even parity over the qualifier and grant
// bytes (3 or 5 by mode), remembers the qualifier, and reports both at the slot end.
// Assumes wide_mode and yellow_en are steady within a slot.
module header_check
    import idle_chk_pkg::*;
#(
    parameter int    SLOT_BYTES  = 16,
    parameter int    HDR_NARROW  = 3,
    parameter int    HDR_WIDE    = 5,
    parameter byte_t YELLOW_CODE = 8'h48,
    localparam int   POS_W       = $clog2(SLOT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [POS_W-1:0] pos,
    input  logic             last_beat,
    input  logic             wide_mode,
    input  logic             yellow_en,
    input  byte_t            din,
    output logic             parity_err,
    output logic             yellow_irq
);

    logic [POS_W-1:0] hdr_len;
    logic             in_hdr;
    logic             par_acc;
    byte_t            pq_q;

    assign hdr_len = wide_mode ? POS_W'(HDR_WIDE) : POS_W'(HDR_NARROW);
    assign in_hdr  = (pos < hdr_len);

    // Collect header parity and the qualifier byte during the header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_acc <= 1'b0;
            pq_q    <= '0;
        end else if (in_valid && in_hdr) begin
            if (pos == '0) begin
                par_acc <= ^din;
                pq_q    <= din;
            end else begin
                par_acc <= par_acc ^ (^din);
            end
        end
    end

    // Issue the parity and yellow pulses in the cycle after the last slot byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err <= 1'b0;
            yellow_irq <= 1'b0;
        end else begin
            parity_err <= in_valid && last_beat && par_acc;
            yellow_irq <= in_valid && last_beat && yellow_en && (pq_q == YELLOW_CODE);
        end
    end

endmodule

// File: rtl/idle_pkt_checker.sv
// Top level: checks idle packets spread over LANES byte lanes (lane 0 is the master).
// It holds one running CRC per lane, checks header parity, and detects yellow packets.
// Assumes byte-aligned lanes that all advance together on in_valid.
module idle_pkt_checker
    import idle_chk_pkg::*;
#(
    parameter int    LANES       = 4,
    parameter int    SLOT_BYTES  = 16,
    parameter int    HDR_NARROW  = 3,
    parameter int    HDR_WIDE    = 5,
    parameter byte_t POLY        = 8'h1D,
    parameter byte_t YELLOW_CODE = 8'h48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*BYTE_W-1:0] lane_data,
    input  logic                    wide_mode,
    input  logic                    yellow_en,
    input  logic [BYTE_W-1:0]       crc_seed,
    input  logic                    seed_load,
    output logic [LANES-1:0]        crc_err,
    output logic                    parity_err,
    output logic                    yellow_irq
);

    localparam int POS_W = $clog2(SLOT_BYTES);

    logic [POS_W-1:0]        pos;
    logic                    last_beat;
    logic [LANES*BYTE_W-1:0] lane_crc_flat;

    slot_tracker #(.SLOT_BYTES(SLOT_BYTES)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pos       (pos),
        .last_beat (last_beat)
    );

    // One CRC engine per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_crc #(.POLY(POLY)) u_crc (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .last_beat (last_beat),
            .seed_load (seed_load),
            .seed      (crc_seed),
            .din       (lane_data[l*BYTE_W +: BYTE_W]),
            .crc_q     (lane_crc_flat[l*BYTE_W +: BYTE_W]),
            .err_pulse (crc_err[l])
        );
    end

    header_check #(
        .SLOT_BYTES  (SLOT_BYTES),
        .HDR_NARROW  (HDR_NARROW),
        .HDR_WIDE    (HDR_WIDE),
        .YELLOW_CODE (YELLOW_CODE)
    ) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .pos        (pos),
        .last_beat  (last_beat),
        .wide_mode  (wide_mode),
        .yellow_en  (yellow_en),
        .din        (lane_data[BYTE_W-1:0]),
        .parity_err (parity_err),
        .yellow_irq (yellow_irq)
    );

endmodule

// File: rtl/idle_pkt_checker_sva.sv
// Property checker for idle_pkt_checker, attached through bind.
// Assumes seed_load only between slots and the first valid byte after reset is byte 0.
module idle_pkt_checker_sva #(
    parameter int LANES      = 4,
    parameter int SLOT_BYTES = 16,
    localparam int POS_W     = $clog2(SLOT_BYTES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                seed_load,
    input logic                yellow_en,
    input logic [7:0]          crc_seed,
    input logic [LANES*8-1:0]  lane_data,
    input logic [POS_W-1:0]    pos,
    input logic [LANES*8-1:0]  lane_crc_flat,
    input logic [LANES-1:0]    crc_err,
    input logic                parity_err,
    input logic                yellow_irq
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BYTES - 1);

    assert_pos_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1));

    assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pos));

    assert_crc_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pos == LAST_POS && !seed_load) |=> lane_crc_flat == $past(lane_data));

    assert_seed_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> lane_crc_flat == {LANES{$past(crc_seed)}});

    assert_yellow_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        yellow_irq |-> $past(yellow_en));

    assert_pulse_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && pos == LAST_POS) |=> (crc_err == '0 && !parity_err && !yellow_irq));

endmodule

bind idle_pkt_checker idle_pkt_checker_sva #(
    .LANES      (LANES),
    .SLOT_BYTES (SLOT_BYTES)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .seed_load     (seed_load),
    .yellow_en     (yellow_en),
    .crc_seed      (crc_seed),
    .lane_data     (lane_data),
    .pos           (pos),
    .lane_crc_flat (lane_crc_flat),
    .crc_err       (crc_err),
    .parity_err    (parity_err),
    .yellow_irq    (yellow_irq)
);

// File: tb/idle_pkt_checker_test.sv
// Bench: a behavioural model predicts every output and is compared on every clock.
module idle_pkt_checker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] lane_data;
    logic        wide_mode;
    logic        yellow_en;
    logic [7:0]  crc_seed;
    logic        seed_load;
    logic [3:0]  crc_err;
    logic        parity_err;
    logic        yellow_irq;

    idle_pkt_checker uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .lane_data (lane_data),
        .wide_mode (wide_mode), .yellow_en (yellow_en), .crc_seed (crc_seed),
        .seed_load (seed_load), .crc_err (crc_err), .parity_err (parity_err),
        .yellow_irq (yellow_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    misses  = 0;
    bit    done    = 1'b0;
    string tag     = "R1";

    // Reference model state.
    int         m_crc [4];
    int         m_pos;
    bit         m_par;
    logic [7:0] m_pq;
    logic [3:0] e_crc;
    bit         e_par;
    bit         e_yel;

    // Remainder of (c ^ d) * x^8 divided by x^8+x^4+x^3+x^2+1.
    function automatic int ref_crc(input int c, input int d);
        int r;
        r = ((c ^ d) & 8'hFF) << 8;
        for (int b = 15; b >= 8; b--)
            if (r[b]) r = r ^ (9'h11D << (b - 8));
        return r & 8'hFF;
    endfunction

    task automatic compare();
        vectors++;
        if (crc_err !== e_crc || parity_err !== e_par || yellow_irq !== e_yel) begin
            misses++;
            $display("FAIL %s: crc_err=%b parity_err=%b yellow_irq=%b, expected %b %b %b",
                     tag, crc_err, parity_err, yellow_irq, e_crc, e_par, e_yel);
        end
    endtask

    // One clock: check the outputs of the last edge, then drive and predict the next.
    task automatic step(input bit v, input logic [31:0] d);
        @(negedge clk);
        compare();
        in_valid  = v;
        lane_data = d;
        e_crc = '0; e_par = 1'b0; e_yel = 1'b0;
        if (v) begin
            if (m_pos == 15) begin
                for (int l = 0; l < 4; l++) begin
                    e_crc[l] = (d[l*8 +: 8] != m_crc[l][7:0]);
                    m_crc[l] = int'(d[l*8 +: 8]);
                end
                e_par = m_par;
                e_yel = yellow_en && (m_pq == 8'h48);
            end else begin
                for (int l = 0; l < 4; l++) m_crc[l] = ref_crc(m_crc[l], int'(d[l*8 +: 8]));
                if (m_pos == 0) begin m_par = ^d[7:0]; m_pq = d[7:0]; end
                else if (m_pos < (wide_mode ? 5 : 3)) m_par = m_par ^ (^d[7:0]);
            end
            m_pos = (m_pos + 1) % 16;
        end
    endtask

    // Build and send one packet; optionally flip one bit of one lane byte.
    task automatic send_pkt(input string t, input bit wide, input logic [39:0] hdr,
                            input int el, input int eb, input int ebit, input bit gap);
        logic [7:0] pk [4][16];
        int c;
        tag = t;
        wide_mode = wide;
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 15; k++)
                pk[l][k] = (((k + l) % 3) == 0) ? 8'hCC : 8'h00;
            if (l == 0)
                for (int k = 0; k < 5; k++) pk[0][k] = hdr[k*8 +: 8];
            c = m_crc[l];
            for (int k = 0; k < 15; k++) c = ref_crc(c, int'(pk[l][k]));
            pk[l][15] = c[7:0];
        end
        if (el >= 0) pk[el][eb][ebit] = ~pk[el][eb][ebit];
        for (int k = 0; k < 16; k++) begin
            step(1'b1, {pk[3][k], pk[2][k], pk[1][k], pk[0][k]});
            if (gap && (k % 4 == 1)) step(1'b0, $urandom);
        end
        step(1'b0, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; lane_data = '0; wide_mode = 1'b0;
        yellow_en = 1'b1; crc_seed = 8'hA5; seed_load = 1'b0;
        e_crc = '0; e_par = 1'b0; e_yel = 1'b0;
        m_pos = 0; m_par = 1'b0; m_pq = '0;
        for (int l = 0; l < 4; l++) m_crc[l] = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle after reset; R2: invalid cycles with noise change nothing.
        tag = "R1";
        step(1'b0, 32'h0);
        tag = "R2";
        for (int i = 0; i < 6; i++) step(1'b0, $urandom);
        // R3 R5: clean narrow packet, even header parity (bytes 03,05,06).
        send_pkt("R3", 1'b0, 40'h00_00_06_05_03, -1, 0, 0, 1'b0);
        // R5: odd header parity.
        send_pkt("R5", 1'b0, 40'h00_00_01_00_00, -1, 0, 0, 1'b0);
        // R5: bytes 3 and 4 are outside the narrow header.
        send_pkt("R5", 1'b0, 40'h10_01_00_00_00, -1, 0, 0, 1'b1);
        // R6: same bytes in wide mode (bytes 3,4 odd together -> even: 01,10), then odd.
        send_pkt("R6", 1'b1, 40'h10_01_00_00_00, -1, 0, 0, 1'b0);
        send_pkt("R6", 1'b1, 40'h00_01_00_00_00, -1, 0, 0, 1'b0);
        // R3: CRC byte error on lane 2 only; R4: next packet clean again.
        send_pkt("R3", 1'b0, 40'h0, 2, 15, 3, 1'b0);
        send_pkt("R4", 1'b0, 40'h0, -1, 0, 0, 1'b0);
        // R3: payload error on master lane byte 9, with gaps (R2).
        send_pkt("R3", 1'b0, 40'h0, 0, 9, 0, 1'b1);
        send_pkt("R4", 1'b1, 40'h0, 3, 0, 7, 1'b0);
        send_pkt("R4", 1'b0, 40'h0, -1, 0, 0, 1'b1);
        // R7: yellow qualifier with detection on, then off.
        send_pkt("R7", 1'b0, 40'h00_00_00_00_48, -1, 0, 0, 1'b0);
        yellow_en = 1'b0;
        send_pkt("R7", 1'b0, 40'h00_00_00_00_48, -1, 0, 0, 1'b0);
        yellow_en = 1'b1;
        send_pkt("R7", 1'b1, 40'h00_00_00_00_49, -1, 0, 0, 1'b0);
        // R8: reload all lanes from a new seed between packets.
        @(negedge clk);
        tag = "R8";
        compare();
        crc_seed = 8'h3C; seed_load = 1'b1;
        for (int l = 0; l < 4; l++) m_crc[l] = 8'h3C;
        e_crc = '0; e_par = 1'b0; e_yel = 1'b0;
        @(negedge clk);
        seed_load = 1'b0;
        send_pkt("R8", 1'b0, 40'h0, -1, 0, 0, 1'b0);
        send_pkt("R9", 1'b0, 40'h0, 1, 4, 2, 1'b1);
        tag = "R9";
        for (int i = 0; i < 4; i++) step(1'b0, $urandom);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule